// File: doc/BRIEF.md
# Interrupt Pending Clear Register Bank

This block holds the pending state of 64 interrupt lines and lets software inspect and cancel it through two 32-bit clear-pending words on a simple register bus. A read of either word returns the live pending bits of the 32 interrupts it covers. A write of ones cancels the pending state of the selected interrupts. Zero bits in the write data have no effect. Hardware request inputs set pending bits on their rising edge.

A separate active-state vector is kept beside the pending vector. The interrupt controller's acknowledge input sets an interrupt's active bit and consumes its pending bit. An exception-return input clears the active bit. Clear-pending writes never change it. Every bus access must be privileged. An unprivileged access is refused with a one-cycle error response. Read data and error are registered and appear one cycle after the access strobe.

Top module: `irq_clrpend_bank`

## Requirements
- R1: The word at offset 0x280 covers interrupts 0 to 31, with data bit k mapped to interrupt k.
- R2: The word at offset 0x284 covers interrupts 32 to 63, with data bit k mapped to interrupt 32+k.
- R3: A privileged read returns, on bus_rdata_o in the cycle after the strobe, a 1 for every interrupt of that word that was pending in the strobe cycle and 0 for the others.
- R4: A privileged write of 1 to a bit clears the pending state of the matching interrupt at the next clock edge.
- R5: A privileged write of 0 to a bit leaves the matching pending bit unchanged.
- R6: A clear-pending write leaves every active bit unchanged.
- R7: An unprivileged access (bus_priv_i low) changes no state, returns read data of zero, and drives bus_err_o high for exactly the one cycle after the strobe.
- R8: After reset all pending bits, all active bits, bus_rdata_o and bus_err_o are 0.
- R9: A 0-to-1 change on irq_req_i[n] sets pending bit n at the next clock edge. A request held high does not set the bit again after it has been cleared.
- R10: If a request edge and a clear write hit the same interrupt in the same cycle, the pending bit ends up set.
- R11: An access to any address other than the two clear-pending offsets reads as zero, changes no state, and raises no error.
- R12: An acknowledge (ack_valid_i with ack_id_i = n) sets active bit n and clears pending bit n. An exception return (eret_valid_i with eret_id_i = n) clears active bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 64 | Interrupt request lines, one per interrupt |
| ack_valid_i | input | 1 | Interrupt acknowledge strobe |
| ack_id_i | input | 6 | Number of the acknowledged interrupt |
| eret_valid_i | input | 1 | Exception-return strobe |
| eret_id_i | input | 6 | Number of the interrupt being returned from |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data, ones select the interrupts to clear |
| bus_priv_i | input | 1 | Access is privileged |
| bus_rdata_o | output | 32 | Registered read data |
| bus_err_o | output | 1 | Registered error response |
| pend_o | output | 64 | Current pending vector |
| active_o | output | 64 | Current active vector |

## Verification
The assertions assume that every input is a known value on each clock edge. They also assume that a strobe lasts a single cycle, so an error pulse is never extended by a second refused access. Acknowledge and exception return are taken to name interrupt numbers inside the 64-line range, which holds because the ID width exactly spans it. The directed stimulus drives all inputs on the falling edge and keeps request edges, acknowledges and bus accesses in separate cycles. The exception is the one scenario that deliberately makes a request edge and a clear collide. Under these conditions each expected pending and read value follows from the bench's own model.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_OK   = 2'd1,
    ACC_DENY = 2'd2,
    ACC_MISS = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pend_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]     BASE_ADDR = 'h280,
  parameter int unsigned           N_WORD    = 2,
  localparam int unsigned          IDX_W     = (N_WORD > 1) ? $clog2(N_WORD) : 1
) (
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              priv_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] offs;
  logic              in_range;

  always_comb begin
    offs     = addr_i - BASE_ADDR;
    in_range = (addr_i >= BASE_ADDR) && (offs[1:0] == 2'b00)
               && ((offs >> 2) < ADDR_W'(N_WORD));
    idx_o    = offs[2 +: IDX_W];
    if (!sel_i)       kind_o = ACC_IDLE;
    else if (!priv_i) kind_o = ACC_DENY;
    else if (in_range) kind_o = ACC_OK;
    else              kind_o = ACC_MISS;
  end
endmodule

// File: rtl/irq_edge_set.sv
module irq_edge_set #(
  parameter int unsigned N_IRQ = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  output logic [N_IRQ-1:0] rise_o
);
  logic [N_IRQ-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;
  end

  assign rise_o = req_i & ~req_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_IRQ = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] set_i,
  input  logic [N_IRQ-1:0] clr_i,
  input  logic [N_IRQ-1:0] ack_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] pend_q, pend_d;

  // hardware set has priority so no request is lost
  assign pend_d = (pend_q & ~(clr_i | ack_i)) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  a_r4_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((pend_q & $past(clr_i) & ~$past(set_i)) == '0));

  a_r5_hold_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pend_q & $past(pend_q & ~clr_i & ~ack_i)) == '0));

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_active_bank.sv
module irq_active_bank #(
  parameter int unsigned N_IRQ = 64,
  localparam int unsigned ID_W = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_valid_i,
  input  logic [ID_W-1:0]  ack_id_i,
  input  logic             eret_valid_i,
  input  logic [ID_W-1:0]  eret_id_i,
  output logic [N_IRQ-1:0] ack_mask_o,
  output logic [N_IRQ-1:0] act_o
);
  logic [N_IRQ-1:0] act_q, eret_mask;

  always_comb begin
    ack_mask_o = '0;
    eret_mask  = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      ack_mask_o[i] = ack_valid_i  && (ack_id_i  == ID_W'(i));
      eret_mask[i]  = eret_valid_i && (eret_id_i == ID_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= (act_q & ~eret_mask) | ack_mask_o;
  end

  assign act_o = act_q;

  a_r12_ack_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i |=> act_q[$past(ack_id_i)]);

  a_r12_eret_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_valid_i && !(ack_valid_i && ack_id_i == eret_id_i)) |=> !act_q[$past(eret_id_i)]);
endmodule

// File: rtl/irq_clrpend_bank.sv
module irq_clrpend_bank
  import irq_pend_pkg::*;
#(
  parameter int unsigned       N_IRQ     = 64,
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h280,
  localparam int unsigned      ID_W      = $clog2(N_IRQ),
  localparam int unsigned      N_WORD    = N_IRQ / WORD_W,
  localparam int unsigned      IDX_W     = (N_WORD > 1) ? $clog2(N_WORD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic              ack_valid_i,
  input  logic [ID_W-1:0]   ack_id_i,
  input  logic              eret_valid_i,
  input  logic [ID_W-1:0]   eret_id_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  logic              bus_priv_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  output logic [N_IRQ-1:0]  pend_o,
  output logic [N_IRQ-1:0]  active_o
);
  acc_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [N_IRQ-1:0]  rise, clr_mask, ack_mask, pend;
  logic [WORD_W-1:0] rd_word;
  logic              acc_ok;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .N_WORD(N_WORD)
  ) u_dec (
    .sel_i(bus_sel_i), .addr_i(bus_addr_i), .priv_i(bus_priv_i),
    .kind_o(kind), .idx_o(idx)
  );

  irq_edge_set #(.N_IRQ(N_IRQ)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(irq_req_i), .rise_o(rise)
  );

  irq_active_bank #(.N_IRQ(N_IRQ)) u_act (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ack_valid_i(ack_valid_i), .ack_id_i(ack_id_i),
    .eret_valid_i(eret_valid_i), .eret_id_i(eret_id_i),
    .ack_mask_o(ack_mask), .act_o(active_o)
  );

  irq_pend_bank #(.N_IRQ(N_IRQ)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(rise), .clr_i(clr_mask),
    .ack_i(ack_mask), .pend_o(pend)
  );

  assign acc_ok = (kind == ACC_OK);

  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    assign clr_mask[w*WORD_W +: WORD_W] =
      (acc_ok && bus_we_i && idx == IDX_W'(w)) ? bus_wdata_i : '0;
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < N_WORD; w++)
      if (idx == IDX_W'(w)) rd_word = pend[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
      bus_err_o   <= 1'b0;
    end else begin
      bus_rdata_o <= (acc_ok && !bus_we_i) ? rd_word : '0;
      bus_err_o   <= (kind == ACC_DENY);
    end
  end

  assign pend_o = pend;

  a_r7_deny_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_priv_i) |=> (bus_err_o && bus_rdata_o == '0));

  a_r7_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_sel_i |=> !bus_err_o);

  a_r6_active_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_valid_i && !eret_valid_i) |=> $stable(active_o));

  a_r11_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == ACC_MISS) |=> (!bus_err_o && bus_rdata_o == '0));
endmodule

// File: tb/tb_irq_clrpend_bank.sv
module tb_irq_clrpend_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_req = '0;
  logic        ack_valid = 1'b0, eret_valid = 1'b0;
  logic [5:0]  ack_id = '0, eret_id = '0;
  logic        sel = 1'b0, we = 1'b0, priv = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [63:0] pend, active;
  logic [63:0] exp_pend = '0, exp_act = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_clrpend_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req),
    .ack_valid_i(ack_valid), .ack_id_i(ack_id),
    .eret_valid_i(eret_valid), .eret_id_i(eret_id),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_priv_i(priv), .bus_rdata_o(rdata), .bus_err_o(err),
    .pend_o(pend), .active_o(active)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] a, input bit w, input logic [31:0] d, input bit p);
    sel = 1'b1; we = w; addr = a; wdata = d; priv = p;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic raise(input int n);
    irq_req[n] = 1'b1;
    @(negedge clk);
    irq_req[n] = 1'b0;
    exp_pend[n] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(pend == '0, "R8 pend", pend, '0);
    chk(active == '0, "R8 active", active, '0);
    chk(rdata == '0 && err == 1'b0, "R8 bus", {31'd0, err, rdata}, '0);
  endtask

  task automatic t_map;
    raise(0); raise(31); raise(7);
    raise(32); raise(63); raise(45);
    chk(pend == exp_pend, "R9 edge sets", pend, exp_pend);
    acc(12'h280, 1'b0, '0, 1'b1);
    chk(rdata == exp_pend[31:0], "R1 R3 word0 read", {32'd0, rdata}, {32'd0, exp_pend[31:0]});
    chk(err == 1'b0, "R3 no err", {63'd0, err}, '0);
    acc(12'h284, 1'b0, '0, 1'b1);
    chk(rdata == exp_pend[63:32], "R2 R3 word1 read", {32'd0, rdata}, {32'd0, exp_pend[63:32]});
  endtask

  task automatic t_clear;
    acc(12'h280, 1'b1, 32'h8000_0001, 1'b1);
    exp_pend[0] = 1'b0; exp_pend[31] = 1'b0;
    chk(pend == exp_pend, "R4 R5 word0 clear", pend, exp_pend);
    acc(12'h284, 1'b1, 32'h0000_2000, 1'b1);
    exp_pend[45] = 1'b0;
    chk(pend == exp_pend, "R2 R4 word1 clear bit13", pend, exp_pend);
    acc(12'h284, 1'b1, 32'h0, 1'b1);
    chk(pend == exp_pend, "R5 zero write", pend, exp_pend);
  endtask

  task automatic t_active;
    raise(40);
    ack_valid = 1'b1; ack_id = 6'd40;
    @(negedge clk);
    ack_valid = 1'b0;
    exp_act[40] = 1'b1; exp_pend[40] = 1'b0;
    chk(active == exp_act, "R12 ack active", active, exp_act);
    chk(pend == exp_pend, "R12 ack clears pend", pend, exp_pend);
    raise(40);
    acc(12'h284, 1'b1, 32'hFFFF_FFFF, 1'b1);
    exp_pend[63:32] = '0;
    chk(pend == exp_pend, "R4 clear all word1", pend, exp_pend);
    chk(active == exp_act, "R6 active kept", active, exp_act);
    eret_valid = 1'b1; eret_id = 6'd40;
    @(negedge clk);
    eret_valid = 1'b0;
    exp_act[40] = 1'b0;
    chk(active == exp_act, "R12 eret clears", active, exp_act);
  endtask

  task automatic t_unpriv;
    raise(3);
    acc(12'h280, 1'b0, '0, 1'b0);
    chk(rdata == '0, "R7 read zero", {32'd0, rdata}, '0);
    chk(err == 1'b1, "R7 err", {63'd0, err}, 64'd1);
    @(negedge clk);
    chk(err == 1'b0, "R7 err one cycle", {63'd0, err}, '0);
    acc(12'h280, 1'b1, 32'h0000_0008, 1'b0);
    chk(pend == exp_pend, "R7 write ignored", pend, exp_pend);
  endtask

  task automatic t_miss;
    acc(12'h288, 1'b1, 32'hFFFF_FFFF, 1'b1);
    chk(pend == exp_pend, "R11 write ignored", pend, exp_pend);
    chk(err == 1'b0, "R11 no err", {63'd0, err}, '0);
    acc(12'h282, 1'b0, '0, 1'b1);
    chk(rdata == '0, "R11 misaligned reads zero", {32'd0, rdata}, '0);
    acc(12'h27C, 1'b0, '0, 1'b1);
    chk(rdata == '0 && err == 1'b0, "R11 below base", {31'd0, err, rdata}, '0);
  endtask

  task automatic t_set_wins;
    irq_req[9] = 1'b1;
    acc(12'h280, 1'b1, 32'h0000_0200, 1'b1);
    irq_req[9] = 1'b0;
    exp_pend[9] = 1'b1;
    chk(pend == exp_pend, "R10 set wins", pend, exp_pend);
    acc(12'h280, 1'b1, 32'h0000_0200, 1'b1);
    exp_pend[9] = 1'b0;
    chk(pend == exp_pend, "R4 later clear", pend, exp_pend);
  endtask

  task automatic t_level;
    irq_req[20] = 1'b1;
    @(negedge clk);
    exp_pend[20] = 1'b1;
    acc(12'h280, 1'b1, 32'h0010_0000, 1'b1);
    exp_pend[20] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(pend == exp_pend, "R9 held level no reset", pend, exp_pend);
    irq_req[20] = 1'b0;
    @(negedge clk);
    irq_req[20] = 1'b1;
    @(negedge clk);
    irq_req[20] = 1'b0;
    exp_pend[20] = 1'b1;
    chk(pend == exp_pend, "R9 new edge sets", pend, exp_pend);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_map();
    t_clear();
    t_active();
    t_unpriv();
    t_miss();
    t_set_wins();
    t_level();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule